// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block brings an asynchronous DRAM with a 2K-row refresh requirement out of power-up and keeps it refreshed. After reset it holds both strobes high through a power-up pause derived from the clock frequency. It then asks for the memory bus and runs a series of wake-up cycles, each containing a RAS pulse. When these are done it raises a ready flag.

From then on an interval timer records one owed refresh for every slice of the retention period. Each slice is the retention time divided by the row count. The block shares the strobes with an access sequencer through a request/grant pair. It requests the bus while any refresh is owed and drives RAS and CAS only while it owns the bus.

Owed refreshes pile up while the grant is withheld, for example during a long page burst. They are all issued back-to-back once the grant returns. If the pile grows past a set limit, the rows can no longer be trusted. In that case the block flags the missed deadline, drops ready and runs the full wake-up again.

A parameter selects between two ways of refreshing. In the CAS-before-RAS variant the DRAM's internal row counter supplies the row. In the RAS-only variant the block drives its own row address.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PAUSE_US x CLK_MHZ clock cycles after reset is released, ras_n and cas_n stay high, bus_req stays low and ready stays low.
- R2: After the pause the block requests the bus and issues exactly WAKE_CYC (default 8) RAS cycles. ready rises only after the last of them and stays low until then.
- R3: In the CAS-before-RAS variant (USE_CBR=1), cas_n is low for at least one sampled cycle before ras_n falls. ras_n stays low for at least RAS_ACT_CYC cycles. ras_n is high for at least RAS_PRE_CYC cycles before the next fall.
- R4: Once the pause is over, one refresh becomes owed every CLK_MHZ x RETENTION_US / ROWS cycles, which is 1953 cycles at the defaults. With the grant always given, successive rises of bus_req are exactly that far apart.
- R5: ras_n and cas_n are both high whenever bus_gnt is low. bus_req stays high from the first owed cycle until the final precharge has ended.
- R6: Refreshes that fall due while the grant is withheld, up to PEND_LIMIT (default 4) of them, are all issued back-to-back once the grant is given. The count is exact, and ready stays high throughout.
- R7: A refresh that falls due while PEND_LIMIT refreshes are already owed has these effects: err_missed goes high and stays high until reset, ready falls, the owed count is discarded, and WAKE_CYC wake-up cycles run before ready rises again.
- R8: In the RAS-only variant (USE_CBR=0), cas_n stays high. row_addr starts at 0 after reset and advances by one, modulo ROWS, after each RAS cycle, so each fall of ras_n presents the next row.
- R9: Asserting reset in the middle of operation clears ready and err_missed, drops bus_req and restarts the power-up pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency given by CLK_MHZ |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Grant from the bus arbiter; held while bus_req is high |
| bus_req | output | 1 | Request for the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low, driven only while granted |
| cas_n | output | 1 | Column strobe, active low, driven only while granted |
| row_addr | output | $clog2(ROWS) | Row to refresh in the RAS-only variant; zero otherwise |
| ready | output | 1 | Initialisation complete; DRAM usable |
| err_missed | output | 1 | Sticky flag: refresh deadline was missed |

## Verification
A wrong owed-refresh count shows as an extra or missing RAS fall in the burst that follows a withheld grant. It can also show as err_missed firing one interval early or late, so the bench withholds the grant for a known number of intervals, measured from a tick it has synchronised to, and counts the falls. A timer that is off by even one cycle moves the spacing between bus_req rises within one interval. A strobe sequencer that is wrong breaks the order of the strobe edges or their widths on the very next refresh. A row counter that is wrong presents the wrong row at the very next RAS fall in the RAS-only variant.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LEAD,
      PH_ACT,
      PH_PRE
   } phase_e;

endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
   parameter int PERIOD = 1953
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("interval_timer: PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = en && (cnt_q == CW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
   import dram_refresh_pkg::*;
#(
   parameter int USE_CBR      = 1,
   parameter int ROWS         = 2048,
   parameter int CAS_LEAD_CYC = 2,
   parameter int RAS_ACT_CYC  = 8,
   parameter int RAS_PRE_CYC  = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   output logic                    busy,
   output logic                    done,
   output logic                    ras_n_o,
   output logic                    cas_n_o,
   output logic [$clog2(ROWS)-1:0] row_o
);
   localparam int RW   = $clog2(ROWS);
   localparam int MAX1 = (CAS_LEAD_CYC > RAS_ACT_CYC) ? CAS_LEAD_CYC : RAS_ACT_CYC;
   localparam int MAXC = (MAX1 > RAS_PRE_CYC) ? MAX1 : RAS_PRE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (CAS_LEAD_CYC < 1 || RAS_ACT_CYC < 1 || RAS_PRE_CYC < 1) begin : g_bad_timing
         $error("strobe_seq: every phase needs at least one cycle");
      end
   endgenerate

   phase_e        ph_q;
   logic [CW-1:0] cnt_q;

   assign busy = (ph_q != PH_IDLE);
   assign done = (ph_q == PH_PRE) && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               ph_q  <= PH_LEAD;
               cnt_q <= CW'(CAS_LEAD_CYC - 1);
            end
            PH_LEAD: if (cnt_q == '0) begin
               ph_q  <= PH_ACT;
               cnt_q <= CW'(RAS_ACT_CYC - 1);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            PH_ACT: if (cnt_q == '0) begin
               ph_q  <= PH_PRE;
               cnt_q <= CW'(RAS_PRE_CYC - 1);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            PH_PRE: if (cnt_q == '0) begin
               ph_q <= PH_IDLE;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ras_n_o = (ph_q != PH_ACT);

   generate
      if (USE_CBR != 0) begin : g_cbr
         assign cas_n_o = !((ph_q == PH_LEAD) || (ph_q == PH_ACT));
         assign row_o   = '0;

         // R3
         cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
      end else begin : g_ras_only
         logic [RW-1:0] row_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               row_q <= '0;
            end else if (done) begin
               row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
            end
         end
         assign cas_n_o = 1'b1;
         assign row_o   = row_q;

         // R8
         row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ras_n_o |-> $stable(row_o));
      end
   endgenerate

   logic [15:0] low_len_q;
   logic [15:0] high_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_len_q  <= '0;
         high_len_q <= 16'(RAS_PRE_CYC);
      end else begin
         low_len_q  <= ras_n_o ? '0 : low_len_q + 1'b1;
         if (!ras_n_o) begin
            high_len_q <= '0;
         end else if (high_len_q < 16'(RAS_PRE_CYC)) begin
            high_len_q <= high_len_q + 1'b1;
         end
      end
   end

   // R3
   act_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |-> (low_len_q >= 16'(RAS_ACT_CYC)));

   // R3
   pre_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (high_len_q >= 16'(RAS_PRE_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int CLK_MHZ      = 125,
   parameter int PAUSE_US     = 200,
   parameter int RETENTION_US = 32000,
   parameter int ROWS         = 2048,
   parameter int WAKE_CYC     = 8,
   parameter int PEND_LIMIT   = 4,
   parameter int CAS_LEAD_CYC = 2,
   parameter int RAS_ACT_CYC  = 8,
   parameter int RAS_PRE_CYC  = 5,
   parameter int USE_CBR      = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_gnt,
   output logic                    bus_req,
   output logic                    ras_n,
   output logic                    cas_n,
   output logic [$clog2(ROWS)-1:0] row_addr,
   output logic                    ready,
   output logic                    err_missed
);
   localparam int PAUSE_CYC    = CLK_MHZ * PAUSE_US;
   localparam int INTERVAL_CYC = (CLK_MHZ * RETENTION_US) / ROWS;
   localparam int PCW          = $clog2(PAUSE_CYC + 1);
   localparam int PW           = $clog2(PEND_LIMIT + 1);
   localparam int WW           = $clog2(WAKE_CYC + 1);

   generate
      if (PEND_LIMIT < 1) begin : g_bad_limit
         $error("dram_refresh_sched: PEND_LIMIT must be at least 1");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("dram_refresh_sched: WAKE_CYC must be at least 1");
      end
      if (PAUSE_CYC < 2) begin : g_bad_pause
         $error("dram_refresh_sched: power-up pause too short");
      end
   endgenerate

   logic           pausing_q;
   logic [PCW-1:0] pause_cnt_q;
   logic [PW-1:0]  pend_q;
   logic [WW-1:0]  wake_left_q;
   logic           in_wake_q;
   logic           ready_q;
   logic           err_q;

   logic tick, busy, done, seq_start;
   logic take_wake, take_pend, overflow;

   // power-up pause
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pausing_q   <= 1'b1;
         pause_cnt_q <= '0;
      end else if (pausing_q) begin
         pause_cnt_q <= pause_cnt_q + 1'b1;
         if (pause_cnt_q == PCW'(PAUSE_CYC - 1)) begin
            pausing_q <= 1'b0;
         end
      end
   end

   interval_timer #(
      .PERIOD(INTERVAL_CYC)
   ) i_interval_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (!pausing_q),
      .tick (tick)
   );

   assign seq_start = !pausing_q && bus_gnt && !busy &&
                      ((wake_left_q != '0) || (pend_q != '0));
   assign take_wake = seq_start && (wake_left_q != '0);
   assign take_pend = seq_start && (wake_left_q == '0);
   assign overflow  = tick && !take_pend && (pend_q == PW'(PEND_LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= '0;
         wake_left_q <= WW'(WAKE_CYC);
         in_wake_q   <= 1'b0;
         ready_q     <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         if (overflow) begin
            pend_q      <= '0;
            wake_left_q <= WW'(WAKE_CYC);
            ready_q     <= 1'b0;
            err_q       <= 1'b1;
         end else begin
            pend_q      <= pend_q + PW'(tick) - PW'(take_pend);
            wake_left_q <= wake_left_q - WW'(take_wake);
            if (done && in_wake_q && (wake_left_q == '0)) begin
               ready_q <= 1'b1;
            end
         end
         if (take_wake) begin
            in_wake_q <= 1'b1;
         end else if (take_pend) begin
            in_wake_q <= 1'b0;
         end
      end
   end

   strobe_seq #(
      .USE_CBR     (USE_CBR),
      .ROWS        (ROWS),
      .CAS_LEAD_CYC(CAS_LEAD_CYC),
      .RAS_ACT_CYC (RAS_ACT_CYC),
      .RAS_PRE_CYC (RAS_PRE_CYC)
   ) i_strobe_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (seq_start),
      .busy   (busy),
      .done   (done),
      .ras_n_o(ras_n),
      .cas_n_o(cas_n),
      .row_o  (row_addr)
   );

   assign bus_req    = !pausing_q && (busy || (wake_left_q != '0) || (pend_q != '0));
   assign ready      = ready_q;
   assign err_missed = err_q;

   // R1
   pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pausing_q |-> (ras_n && cas_n && !bus_req && !ready));

   // R5
   strobe_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> bus_req);

   // R2
   ready_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (wake_left_q == '0));

   // R6
   pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= PW'(PEND_LIMIT));

   // R7
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> err_missed);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_missed |=> err_missed);

endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
   localparam int PAUSE_CYC = 125 * 200;
   localparam int INTERVAL  = (125 * 32000) / 2048;
   localparam int WAKE      = 8;
   localparam int RAS_ACT   = 8;
   localparam int RAS_PRE   = 5;
   localparam int RW        = 11;

   // stimulus table: intervals the grant is withheld, expected RAS falls, expected err
   localparam int NVEC = 4;
   localparam int HOLD  [NVEC] = '{1, 2, 4, 5};
   localparam int EFALLS[NVEC] = '{1, 2, 4, 8};
   localparam int EERR  [NVEC] = '{0, 0, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic allow = 1'b1;
   always #4 clk = ~clk;

   logic bus_req, bus_gnt, ras_n, cas_n, ready, err_missed;
   logic [RW-1:0] row_addr;
   logic req_ro, ras_ro, cas_ro, rdy_ro, err_ro;
   logic [RW-1:0] row_ro;

   assign bus_gnt = bus_req & allow;

   dram_refresh_sched i_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
      .ready(ready), .err_missed(err_missed));

   dram_refresh_sched #(.USE_CBR(0)) i_dram_refresh_sched_ro (
      .clk(clk), .rst_n(rst_n), .bus_gnt(req_ro), .bus_req(req_ro),
      .ras_n(ras_ro), .cas_n(cas_ro), .row_addr(row_ro),
      .ready(rdy_ro), .err_missed(err_ro));

   int n_checks = 0, n_fail = 0;
   int cyc = 0;
   bit finished = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // strobe monitor for the main instance
   int falls = 0, v_order = 0, v_act = 0, v_pre = 0, v_gnt = 0;
   int low_len = 0, high_len = 100;
   logic p_ras = 1'b1, p_cas = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_ras && !ras_n) begin
            falls++;
            if (cas_n || p_cas) v_order++;
            if (high_len < RAS_PRE) v_pre++;
            low_len = 1;
         end else if (!ras_n) begin
            low_len++;
         end else if (!p_ras && ras_n) begin
            if (low_len < RAS_ACT) v_act++;
            high_len = 1;
         end else begin
            high_len++;
         end
         if (!bus_gnt && (!ras_n || !cas_n)) v_gnt++;
      end
      p_ras = ras_n;
      p_cas = cas_n;
   end

   // monitor for the RAS-only instance
   int ro_falls = 0, ro_bad = 0, ro_exp = 0;
   logic p_ras_ro = 1'b1;
   always @(negedge clk) begin
      if (!rst_n) begin
         ro_exp = 0;
      end else begin
         if (!cas_ro) ro_bad++;
         if (p_ras_ro && !ras_ro) begin
            ro_falls++;
            if (int'(row_ro) != ro_exp) ro_bad++;
            ro_exp = (ro_exp + 1) % 2048;
         end
      end
      p_ras_ro = ras_ro;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_drain();
      int guard = 0;
      @(negedge clk);
      while (bus_req && guard < 4000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic sync_rise(output int t);
      int guard = 0;
      while (bus_req && guard < 4000) begin @(negedge clk); guard++; end
      guard = 0;
      while (!bus_req && guard < 4000) begin @(negedge clk); guard++; end
      t = cyc;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      finished = 1;
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         summary();
      end
   end

   initial begin
      int t0, t1, t2, base, guard;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: quiet pause
      repeat (PAUSE_CYC - 2) @(negedge clk);
      check(bus_req == 1'b0, "R1 bus_req during pause", bus_req, 0);
      check(ras_n && cas_n, "R1 strobes during pause", {ras_n, cas_n}, 3);
      check(ready == 1'b0, "R1 ready during pause", ready, 0);
      // R2: wake-up
      guard = 0;
      while (!ready && guard < 1000) begin @(negedge clk); guard++; end
      check(ready == 1'b1, "R2 ready after wake-up", ready, 1);
      check(falls == WAKE, "R2 wake-up RAS cycles", falls, WAKE);
      // R4: interval spacing
      sync_rise(t1);
      wait_drain();
      sync_rise(t2);
      wait_drain();
      check(t2 - t1 == INTERVAL, "R4 refresh interval", t2 - t1, INTERVAL);
      // R6 / R7: table walk
      for (int i = 0; i < NVEC; i++) begin
         sync_rise(t0);
         wait_drain();
         allow = 1'b0;
         base = falls;
         while (cyc < t0 + HOLD[i] * INTERVAL + 10) @(negedge clk);
         check(falls == base, "R5 no cycle while grant withheld", falls - base, 0);
         if (EERR[i] != 0)
            check(ready == 1'b0, "R7 ready dropped on miss", ready, 0);
         else
            check(ready == 1'b1, "R6 ready held while owed", ready, 1);
         allow = 1'b1;
         wait_drain();
         check(falls - base == EFALLS[i], (EERR[i] != 0) ? "R7 repeated wake-up" : "R6 owed refreshes",
               falls - base, EFALLS[i]);
         check(int'(err_missed) == EERR[i], "R7 err_missed", err_missed, EERR[i]);
         check(ready == 1'b1, "R6 ready after burst", ready, 1);
      end
      // R3 / R5 strobe monitor results
      check(v_order == 0, "R3 CAS before RAS", v_order, 0);
      check(v_act == 0, "R3 RAS active width", v_act, 0);
      check(v_pre == 0, "R3 RAS precharge width", v_pre, 0);
      check(v_gnt == 0, "R5 strobes only with grant", v_gnt, 0);
      // R8: RAS-only variant
      check(ro_falls >= WAKE, "R8 RAS-only cycles issued", ro_falls, WAKE);
      check(ro_bad == 0, "R8 CAS high and rows in order", ro_bad, 0);
      check(int'(row_ro) == ro_exp, "R8 row address after last cycle", row_ro, ro_exp);
      // R9: reset mid-operation
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      check(ready == 1'b0, "R9 ready cleared", ready, 0);
      check(err_missed == 1'b0, "R9 err cleared", err_missed, 0);
      check(bus_req == 1'b0, "R9 pause restarted", bus_req, 0);
      check(ras_n && cas_n, "R9 strobes idle", {ras_n, cas_n}, 3);
      summary();
   end
endmodule